// File: doc/BRIEF.md
# Modulo-5 and Quotient Event Counter

The block counts pulses that arrive on a single event line and presents the running total split into two fields: the total modulo 5 on a 3-bit remainder output, and the total divided by 5 on a 4-bit quotient output. Pulses may come at a steady rate or at irregular times. The line rests low between pulses.

The event line is not used as a clock. It is sampled on the system clock through a two-flop synchronizer. A rising-edge detector then turns each pulse into a single count step, however many clocks the pulse lasts. Each time the remainder wraps from 4 back to 0, the quotient advances by one. Together the two fields always hold the total split into its remainder and quotient by five. A clear input zeroes both fields at once. It can be used to start a new measurement without a full reset.

Top module: `div5_event_counter`

## Requirements
- R1: The remainder output only ever holds 0 to 4. Each counted event that finds it below 4 raises it by exactly one and leaves the quotient unchanged.
- R2: An event counted while the remainder is 4 sets the remainder to 0 and raises the quotient by one, in the same clock edge.
- R3: The quotient is 4 bits wide. An event that finds remainder 4 and quotient 15 leaves both fields at 0, with no other indication.
- R4: While clear is high at a rising clock edge, both fields become 0 at that edge.
- R5: When clear is high in the same cycle in which an event would be counted, clear wins. That event is lost and both fields read 0.
- R6: A pulse on the event line counts once, whether it stays high for one clock or for many.
- R7: Taking the first rising clock edge at which the event line is sampled high as edge 1, the outputs change at edge 3 and not before.
- R8: With synchronous reset high at a clock edge, both fields read 0 after that edge.
- R9: Without an event and without clear, both fields hold their values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| clr | input | 1 | Synchronous clear of both fields, active high |
| evt_in | input | 1 | Event line, idle low, may be asynchronous to clk |
| rem_o | output | 3 | Running total modulo 5 |
| quo_o | output | 4 | Running total divided by 5, wrapping after 15 |

## Verification
The assertions assume that a counted step never arrives on two consecutive clocks. They rely on the event line returning low for at least one sampled clock between pulses, so that the edge detector sees a fresh rise. The stimulus drives the event line and clear only at falling clock edges. Every pulse is followed by at least one low cycle, and the counter is given three settling cycles before its expected value is compared. Clear is held across the edge at which a pulse's step lands, which gives the coincident case for the priority check.

// File: rtl/evt_div5_pkg.sv
package evt_div5_pkg;

    parameter int unsigned MODULUS     = 5;
    parameter int unsigned REM_W       = $clog2(MODULUS);
    parameter int unsigned QUO_W       = 4;
    parameter int unsigned SYNC_STAGES = 2;

    typedef logic [REM_W-1:0] rem_t;
    typedef logic [QUO_W-1:0] quo_t;

    // Remainder in the low bits, quotient above it
    typedef struct packed {
        quo_t quo;
        rem_t rem;
    } tally_t;

    localparam rem_t REM_LAST = rem_t'(MODULUS - 1);

    // One counted event applied to the split total
    function automatic tally_t tally_advance(tally_t cur);
        tally_t nxt;
        if (cur.rem == REM_LAST) begin
            nxt.rem = '0;
            nxt.quo = cur.quo + quo_t'(1);
        end else begin
            nxt.rem = cur.rem + rem_t'(1);
            nxt.quo = cur.quo;
        end
        return nxt;
    endfunction

endpackage

// File: rtl/evt_rise_sync.sv
module evt_rise_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic async_in,
    output logic rise_o
);
    logic [STAGES-1:0] chain;
    logic              last_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            chain  <= '0;
            last_q <= 1'b0;
        end else begin
            chain[0] <= async_in;
            for (int i = 1; i < STAGES; i++) begin
                chain[i] <= chain[i-1];
            end
            last_q <= chain[STAGES-1];
        end
    end

    assign rise_o = chain[STAGES-1] & ~last_q;

    // R6
    single_step_chk: assert property (@(posedge clk) disable iff (rst)
        rise_o |=> !rise_o);

endmodule

// File: rtl/mod_quot_counter.sv
module mod_quot_counter
    import evt_div5_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   clr,
    input  logic   step,
    output tally_t tally_o
);
    tally_t tally_q;

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            tally_q <= '0;
        end else if (step) begin
            tally_q <= tally_advance(tally_q);
        end
    end

    assign tally_o = tally_q;

    // R1
    rem_range_chk: assert property (@(posedge clk) disable iff (rst)
        tally_q.rem <= REM_LAST);

    // R1
    rem_step_chk: assert property (@(posedge clk) disable iff (rst)
        (!clr && step && tally_q.rem != REM_LAST) |=>
            (tally_q.rem == $past(tally_q.rem) + rem_t'(1)) && $stable(tally_q.quo));

    // R2
    rem_wrap_chk: assert property (@(posedge clk) disable iff (rst)
        (!clr && step && tally_q.rem == REM_LAST) |=>
            (tally_q.rem == '0) && (tally_q.quo == $past(tally_q.quo) + quo_t'(1)));

    // R4
    clear_zero_chk: assert property (@(posedge clk) disable iff (rst)
        clr |=> (tally_q == '0));

    // R5
    clear_wins_chk: assert property (@(posedge clk) disable iff (rst)
        (clr && step) |=> (tally_q.rem == '0) && (tally_q.quo == '0));

    // R9
    hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!clr && !step) |=> $stable(tally_q));

endmodule

// File: rtl/div5_event_counter.sv
module div5_event_counter
    import evt_div5_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             clr,
    input  logic             evt_in,
    output logic [REM_W-1:0] rem_o,
    output logic [QUO_W-1:0] quo_o
);
    logic   step;
    tally_t tally;

    evt_rise_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst      (rst),
        .async_in (evt_in),
        .rise_o   (step)
    );

    mod_quot_counter u_count (
        .clk     (clk),
        .rst     (rst),
        .clr     (clr),
        .step    (step),
        .tally_o (tally)
    );

    assign rem_o = tally.rem;
    assign quo_o = tally.quo;

endmodule

// File: tb/tb_div5_event_counter.sv
module tb_div5_event_counter;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       clr = 1'b0;
    logic       evt_in = 1'b0;
    logic [2:0] rem_o;
    logic [3:0] quo_o;

    int unsigned n_vec  = 0;
    int unsigned n_bad  = 0;
    int unsigned total  = 0;
    bit          done   = 1'b0;

    typedef struct {
        int    rem;
        int    quo;
        string req;
    } exp_t;

    exp_t sb_q[$];

    always #4 clk = ~clk;

    div5_event_counter dut (
        .clk    (clk),
        .rst    (rst),
        .clr    (clr),
        .evt_in (evt_in),
        .rem_o  (rem_o),
        .quo_o  (quo_o)
    );

    task automatic compare(input int r, input int q, input string req);
        n_vec++;
        if (int'(rem_o) != r || int'(quo_o) != q) begin
            n_bad++;
            $display("FAIL %s: rem=%0d quo=%0d expected rem=%0d quo=%0d",
                     req, rem_o, quo_o, r, q);
        end
    endtask

    // Monitor: pops each expected item and compares at a falling edge
    initial begin
        forever begin
            @(negedge clk);
            if (sb_q.size() > 0) begin
                exp_t e;
                e = sb_q.pop_front();
                compare(e.rem, e.quo, e.req);
            end
        end
    end

    task automatic push_expect(input string req);
        exp_t e;
        e.rem = total % 5;
        e.quo = (total / 5) % 16;
        e.req = req;
        sb_q.push_back(e);
        @(negedge clk);
    endtask

    task automatic settle();
        repeat (3) @(negedge clk);
    endtask

    task automatic pulse(input int hi, input string req);
        evt_in = 1'b1;
        repeat (hi) @(negedge clk);
        evt_in = 1'b0;
        settle();
        total++;
        push_expect(req);
    endtask

    task automatic do_clear(input string req);
        clr = 1'b1;
        @(negedge clk);
        clr = 1'b0;
        settle();
        total = 0;
        push_expect(req);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R8: reset state
        push_expect("R8");

        // R1: steps 1..4
        for (int i = 0; i < 4; i++) pulse(1, "R1");
        // R2: fifth pulse wraps remainder, quotient to 1
        pulse(1, "R2");

        // R9: idle holds
        repeat (10) @(negedge clk);
        push_expect("R9");

        // R6: long and irregular pulses count once each
        pulse(17, "R6");
        pulse(2, "R6");
        pulse(40, "R6");

        // R7: latency; evt_in rises before edge 1
        evt_in = 1'b1;
        @(negedge clk);                 // after edge 1
        @(negedge clk);                 // after edge 2
        n_vec++;
        if (int'(rem_o) != total % 5) begin
            n_bad++;
            $display("FAIL R7: early change rem=%0d expected %0d", rem_o, total % 5);
        end
        @(negedge clk);                 // after edge 3
        total++;
        compare(total % 5, (total / 5) % 16, "R7");
        evt_in = 1'b0;
        settle();

        // R4: clear mid-count
        pulse(1, "R1");
        do_clear("R4");

        // R5: clear held across the edge where the step lands
        evt_in = 1'b1;
        clr = 1'b1;
        repeat (4) @(negedge clk);
        evt_in = 1'b0;
        clr = 1'b0;
        settle();
        push_expect("R5");

        // R3: run to remainder 4, quotient 15, then wrap to 0/0
        for (int i = 0; i < 79; i++) pulse(1 + (i % 3), "R2");
        push_expect("R3");
        pulse(1, "R3");
        pulse(1, "R3");

        // R8: reset mid-count
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        total = 0;
        push_expect("R8");

        while (sb_q.size() > 0) @(negedge clk);
        @(negedge clk);
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: run did not complete, expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

endmodule